// File: doc/BRIEF.md
# Input Change Detector with Interrupt

This block watches a small group of general-purpose input pins on behalf of a serial-bus register front end. Each pin passes through a two-flop synchroniser. The synchronised levels are compared with a stored snapshot, and any difference sets a per-pin change flag. The flag stays set until the next bus access. Each pin also has an enable bit in a mask register. An enabled change drives an active-low interrupt that stays asserted until the host next touches the device.

The front end supplies four strobes and levels:
- an acknowledge pulse for every read or write access, which reloads the snapshot, clears every flag and releases the interrupt;
- a level that is high while a read sequence is in progress;
- a STOP pulse;
- a bus-abort pulse.

While a read is in progress, a new interrupt is held back. It is raised at STOP only if no later acknowledge has already captured the changed data for the host. The bus-abort pulse ends the transaction in the same way as STOP, and it never releases an interrupt that is already asserted.

Top module: `chg_irq_unit`

## Requirements
- R1: During and after synchronous reset, `flags_o` is 0, `irq_n_o` is 1 and `mask_o` reads 8'h3C, which enables all four pins. The snapshot is taken from the synchronised pins, so stable pins raise no flag.
- R2: `levels_o` follows `pins_i` two clock edges after a change. The matching flag and the interrupt respond on the third edge.
- R3: Flag bit i sets when synchronised pin i differs from snapshot bit i. It stays set when the pin returns to its earlier level, until the next acknowledge.
- R4: An `acc_ack_i` pulse does three things on the same edge: it reloads the snapshot from the synchronised pins, clears all flags and releases the interrupt (`irq_n_o` = 1).
- R5: Flags set whatever the mask holds. A change on a pin whose enable bit is 0 leaves `irq_n_o` at 1.
- R6: Outside a read, a change on an enabled pin drives `irq_n_o` to 0. It stays 0 after the pin returns, until an acknowledge.
- R7: While `rd_busy_i` is 1, `irq_n_o` does not fall. A qualifying change seen during the read drives `irq_n_o` to 0 on the edge that samples `stop_i`.
- R8: If an acknowledge arrives during the read after the change, the held-back interrupt is dropped and STOP leaves `irq_n_o` at 1.
- R9: `bus_abort_i` never releases an asserted interrupt. It ends a read as STOP does.
- R10: A `mask_we_i` write stores only bits [5:2] of `mask_wdata_i`, and the other bits read back as 0. Bit 2+i enables pin i.
- R11: A synchronised change that is present on the acknowledge edge goes into the snapshot and sets no flag. A change that reaches the synchronised level one edge after the acknowledge sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | 4 | Asynchronous monitored pins |
| acc_ack_i | input | 1 | Pulse at the acknowledge of any read or write access |
| rd_busy_i | input | 1 | High while a read sequence is in progress |
| stop_i | input | 1 | Pulse when STOP is seen |
| bus_abort_i | input | 1 | Pulse when the bus reset aborts a transaction |
| mask_we_i | input | 1 | Mask register write enable |
| mask_wdata_i | input | 8 | Mask write data; bits [5:2] are the enables |
| mask_o | output | 8 | Mask register readback |
| flags_o | output | 4 | Sticky change flags |
| levels_o | output | 4 | Synchronised pin levels |
| irq_n_o | output | 1 | Active-low latching interrupt |

## Verification
Two functions can fall on the same edge: the acknowledge that reloads the snapshot, and an input change reaching the synchronised level. The bench places the acknowledge on the edge where the change lands, and again one edge earlier.

It judges each placement by the flags. In the first case no flag may set, and a later return of the pin must set one, which shows that the snapshot took the new level. In the second case the flag must set on the following edge.

A second overlap is also driven: a change arriving during a read, and an acknowledge or STOP that ends it. The judgement is whether the interrupt appears at STOP.

// File: rtl/chg_irq_pkg.sv
package chg_irq_pkg;
    localparam int unsigned PIN_N  = 4;
    localparam int unsigned EN_LSB = 2;
    localparam int unsigned REG_W  = 8;

    typedef struct packed {
        logic ack;
        logic rd;
        logic stop;
        logic abort;
    } bus_evt_t;

    function automatic logic txn_end(input bus_evt_t ev);
        return ev.stop | ev.abort;
    endfunction
endpackage

// File: rtl/chg_sync.sv
module chg_sync #(
    parameter int unsigned N      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) stg[0] <= d;
            end else begin : g_next
                always_ff @(posedge clk) stg[s] <= stg[s-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/chg_flags.sv
module chg_flags #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ack,
    input  logic [N-1:0] live,
    output logic [N-1:0] flags_q,
    output logic [N-1:0] diff
);
    logic [N-1:0] snap_q;

    // The acknowledge edge takes the live level into the snapshot, so nothing is compared then.
    assign diff = ack ? '0 : (live ^ snap_q);

    always_ff @(posedge clk) begin
        if (rst || ack) begin
            snap_q  <= live;
            flags_q <= '0;
        end else begin
            flags_q <= flags_q | diff;
        end
    end

    // R4
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> (flags_q == '0));

    // R3
    flags_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !ack |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

// File: rtl/chg_irq_ctl.sv
module chg_irq_ctl
    import chg_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     hit,
    input  bus_evt_t ev,
    output logic     irq_q
);
    logic pend_q;
    logic irq_d, pend_d;

    always_comb begin
        irq_d  = irq_q;
        pend_d = pend_q;
        if (ev.ack) begin
            irq_d  = 1'b0;
            pend_d = 1'b0;
        end else begin
            if (hit && ev.rd)  pend_d = 1'b1;
            if (hit && !ev.rd) irq_d  = 1'b1;
            if (txn_end(ev) && pend_d) begin
                irq_d  = 1'b1;
                pend_d = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            irq_q  <= irq_d;
            pend_q <= pend_d;
        end
    end

    // R4
    ack_release_chk: assert property (@(posedge clk) disable iff (rst)
        ev.ack |=> !irq_q);

    // R7
    read_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.rd && !ev.stop && !ev.abort) |=> !$rose(irq_q));

    // R9
    abort_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.abort && !ev.ack && irq_q) |=> irq_q);
endmodule

// File: rtl/chg_irq_unit.sv
module chg_irq_unit
    import chg_irq_pkg::*;
#(
    parameter int unsigned N   = PIN_N,
    parameter int unsigned LSB = EN_LSB,
    parameter int unsigned RW  = REG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  pins_i,
    input  logic          acc_ack_i,
    input  logic          rd_busy_i,
    input  logic          stop_i,
    input  logic          bus_abort_i,
    input  logic          mask_we_i,
    input  logic [RW-1:0] mask_wdata_i,
    output logic [RW-1:0] mask_o,
    output logic [N-1:0]  flags_o,
    output logic [N-1:0]  levels_o,
    output logic          irq_n_o
);
    localparam logic [RW-1:0] EN_FIELD =
        {{(RW-N-LSB){1'b0}}, {N{1'b1}}, {LSB{1'b0}}};

    logic [RW-1:0] mask_q;
    logic [N-1:0]  live, diff, flags, en;
    logic          hit, irq;
    bus_evt_t      ev;

    assign ev = '{ack: acc_ack_i, rd: rd_busy_i, stop: stop_i, abort: bus_abort_i};

    always_ff @(posedge clk) begin
        if (rst)            mask_q <= EN_FIELD;
        else if (mask_we_i) mask_q <= mask_wdata_i & EN_FIELD;
    end

    assign en  = mask_q[LSB +: N];
    assign hit = |((flags | diff) & en);

    chg_sync #(.N(N), .STAGES(2)) sync_i (
        .clk (clk),
        .d   (pins_i),
        .q   (live)
    );

    chg_flags #(.N(N)) flags_i (
        .clk     (clk),
        .rst     (rst),
        .ack     (acc_ack_i),
        .live    (live),
        .flags_q (flags),
        .diff    (diff)
    );

    chg_irq_ctl ctl_i (
        .clk   (clk),
        .rst   (rst),
        .hit   (hit),
        .ev    (ev),
        .irq_q (irq)
    );

    assign mask_o   = mask_q;
    assign flags_o  = flags;
    assign levels_o = live;
    assign irq_n_o  = ~irq;

    // R10
    mask_store_chk: assert property (@(posedge clk) disable iff (rst)
        mask_we_i |=> (mask_o == ($past(mask_wdata_i) & EN_FIELD)));
endmodule

// File: tb/chg_irq_unit_tb.sv
module chg_irq_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] pins = 4'h0;
    logic       ack = 1'b0, rd = 1'b0, stp = 1'b0, abrt = 1'b0, we = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] mask_o;
    logic [3:0] flags_o, levels_o;
    logic       irq_n_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    chg_irq_unit dut_i (
        .clk(clk), .rst(rst), .pins_i(pins), .acc_ack_i(ack), .rd_busy_i(rd),
        .stop_i(stp), .bus_abort_i(abrt), .mask_we_i(we), .mask_wdata_i(wdata),
        .mask_o(mask_o), .flags_o(flags_o), .levels_o(levels_o), .irq_n_o(irq_n_o)
    );

    typedef struct packed {
        logic [3:0] base;
        logic [3:0] nxt;
        logic [3:0] en;
        logic [3:0] exp_f;
        logic       exp_irq_n;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{4'h0, 4'h1, 4'hF, 4'h1, 1'b0},
        '{4'h0, 4'h0, 4'hF, 4'h0, 1'b1},
        '{4'hF, 4'h0, 4'h0, 4'hF, 1'b1},
        '{4'h5, 4'hA, 4'h1, 4'hF, 1'b0},
        '{4'h3, 4'h3, 4'hF, 4'h0, 1'b1},
        '{4'h0, 4'h8, 4'h7, 4'h8, 1'b1},
        '{4'h0, 4'h8, 4'h8, 4'h8, 1'b0},
        '{4'h6, 4'h4, 4'h2, 4'h2, 1'b0}
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse_ack();
        ack = 1'b1; step(1); ack = 1'b0;
    endtask

    task automatic wr_mask(input logic [7:0] v);
        we = 1'b1; wdata = v; step(1); we = 1'b0;
    endtask

    initial begin
        step(5);
        // R1 reset values
        chk("R1 flags", {4'h0, flags_o}, 8'h00);
        chk("R1 irq_n", {7'h0, irq_n_o}, 8'h01);
        chk("R1 mask", mask_o, 8'h3C);
        rst = 1'b0;
        step(3);
        chk("R1 quiet after reset", {4'h0, flags_o}, 8'h00);

        // R3 R5 R6 vector walk
        for (int i = 0; i < 8; i++) begin
            wr_mask({2'b00, VECS[i].en, 2'b00});
            pins = VECS[i].base;
            step(3);
            pulse_ack();
            pins = VECS[i].nxt;
            step(3);
            chk($sformatf("R3/R5/R6 vec%0d", i),
                {3'b0, flags_o, irq_n_o}, {3'b0, VECS[i].exp_f, VECS[i].exp_irq_n});
        end
        pulse_ack();
        wr_mask(8'hFF);

        // R10 mask write keeps only the enable field
        chk("R10 mask ff", mask_o, 8'h3C);
        wr_mask(8'h04);
        chk("R10 mask 04", mask_o, 8'h04);
        pins = pins ^ 4'h2;
        step(3);
        chk("R10 pin1 disabled irq_n", {7'h0, irq_n_o}, 8'h01);
        chk("R10 pin1 flag", {4'h0, flags_o}, 8'h02);
        wr_mask(8'h3C);
        pulse_ack();

        // R2 synchroniser latency
        pins = 4'h0; step(3); pulse_ack();
        pins = 4'h1;
        step(1);
        chk("R2 level after 1 edge", {4'h0, levels_o}, 8'h00);
        step(1);
        chk("R2 level after 2 edges", {4'h0, levels_o}, 8'h01);
        chk("R2 flag not yet", {4'h0, flags_o}, 8'h00);
        step(1);
        chk("R2 flag on third edge", {4'h0, flags_o}, 8'h01);

        // R6 R3 sticky through a return
        pins = 4'h0;
        step(3);
        chk("R3 flag sticky", {4'h0, flags_o}, 8'h01);
        chk("R6 irq latched", {7'h0, irq_n_o}, 8'h00);

        // R9 abort keeps an asserted interrupt
        abrt = 1'b1; step(1); abrt = 1'b0;
        step(1);
        chk("R9 irq kept", {7'h0, irq_n_o}, 8'h00);

        // R4 ack clears flags and releases
        pulse_ack();
        chk("R4 flags cleared", {4'h0, flags_o}, 8'h00);
        chk("R4 irq released", {7'h0, irq_n_o}, 8'h01);

        // R7 deferral until STOP
        rd = 1'b1;
        pins = 4'h4;
        step(4);
        chk("R7 held during read", {7'h0, irq_n_o}, 8'h01);
        chk("R7 flag during read", {4'h0, flags_o}, 8'h04);
        stp = 1'b1; rd = 1'b0; step(1); stp = 1'b0;
        chk("R7 irq at STOP", {7'h0, irq_n_o}, 8'h00);
        pulse_ack();

        // R8 dropped when data read before STOP
        rd = 1'b1;
        pins = 4'h0;
        step(4);
        pulse_ack();
        stp = 1'b1; rd = 1'b0; step(1); stp = 1'b0;
        step(1);
        chk("R8 no irq at STOP", {7'h0, irq_n_o}, 8'h01);
        chk("R8 flags", {4'h0, flags_o}, 8'h00);

        // R9 abort ends a read like STOP
        rd = 1'b1;
        pins = 4'h8;
        step(4);
        abrt = 1'b1; rd = 1'b0; step(1); abrt = 1'b0;
        chk("R9 abort ends read", {7'h0, irq_n_o}, 8'h00);
        pulse_ack();

        // R11 change on the ack edge goes into the snapshot
        pins = 4'h9;
        step(2);
        pulse_ack();
        step(3);
        chk("R11 coincident no flag", {4'h0, flags_o}, 8'h00);
        chk("R11 coincident no irq", {7'h0, irq_n_o}, 8'h01);
        pins = 4'h8;
        step(3);
        chk("R11 snapshot held new level", {4'h0, flags_o}, 8'h01);
        pulse_ack();

        // R11 change one edge after the ack is flagged
        pins = 4'hA;
        step(1);
        pulse_ack();
        step(2);
        chk("R11 late change flagged", {4'h0, flags_o}, 8'h02);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule